// File: doc/BRIEF.md
# 10BASE-T Receive Nibble Formatter

This block sits after the Manchester decoder in a 10 Mb/s receive path. It takes decoded line bits, one per bit strobe, plus a frame-end pulse, and turns them into media-independent-interface receive nibbles with a data-valid flag and a carrier flag. It locks onto the alternating preamble, aligns nibbles to it, and recognises the start-of-frame delimiter. It then either hides the preamble behind a low data-valid or passes it through.

A frame whose length is not a whole number of bytes is finished by the block. A short tail is padded with ones. A tail longer than one nibble keeps only its complete nibble. A second configuration input chooses whether carrier drops at once on the frame-end pulse or waits until data-valid falls. Output nibbles lag the line by one nibble time. Each one holds for four bit strobes, so the block works with any strobe rate up to one bit per clock.

Top module: `rx_nib_fmt`

## Requirements
- R1: Out of reset, and whenever `rx_dv_o` is low, `rxd_o` is 0. After reset `rx_dv_o` and `crs_o` are 0.
- R2: The preamble is detected on a strobe with bit 0 once at least `PRE_BITS` (default 8) consecutive alternating bits have been seen. Bits gather into nibbles least-significant bit first, and the bit after detection starts a nibble. An aligned preamble nibble is therefore 0x5 and the delimiter nibble (bits 1,0,1,1) is 0xD.
- R3: With `pre_pass_i`=0, `crs_o` rises on the cycle after detection and `rx_dv_o` stays low through the preamble. `rx_dv_o` rises on the delimiter nibble's last bit. The nibbles shown are then 0x5, then 0xD, then the body.
- R4: With `pre_pass_i`=1, `rx_dv_o` and `crs_o` rise together on the first nibble boundary after detection. Every preamble nibble from detection onward shows as 0x5, followed by 0xD and the body.
- R5: After detection but before the delimiter, an aligned nibble other than 0x5 or 0xD, or a frame-end pulse, returns the block to idle with `rx_dv_o` and `crs_o` low.
- R6: `rxd_o` and `rx_dv_o` change only on a cycle with a bit strobe or a frame-end pulse. A nibble appears one nibble time after its last bit and holds for four strobes.
- R7: If the body ends 1 to 3 bits past a byte, those bits are sent as one more nibble with the missing upper positions set to 1. A tail of exactly 4 bits is sent unchanged.
- R8: If the body ends 5 to 7 bits past a byte, the complete first tail nibble is sent and the partial second one is dropped.
- R9: With `crs_sync_i`=0, `crs_o` falls on the cycle after the frame-end pulse. With `crs_sync_i`=1, it falls on the same cycle as `rx_dv_o`.
- R10: After the frame-end pulse, each remaining nibble holds for four strobes, and `rx_dv_o` then falls. Bit values strobed during this drain are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| bit_i | input | 1 | Decoded line bit |
| bit_vld_i | input | 1 | Strobe: `bit_i` holds a new bit this cycle |
| eof_i | input | 1 | Frame-end pulse from the decoder |
| pre_pass_i | input | 1 | 1 passes the preamble, 0 strips it |
| crs_sync_i | input | 1 | 1 holds carrier until data-valid falls |
| rxd_o | output | 4 | Receive nibble |
| rx_dv_o | output | 1 | Receive data valid |
| crs_o | output | 1 | Carrier sense |

## Verification
The properties assume the following about the inputs:
- The frame-end pulse never shares a cycle with a bit strobe.
- Both configuration inputs stay fixed for the whole of a frame.
- Bit strobes keep arriving after the frame end, so the tail can drain.

The stimulus changes the configuration only while the block is idle. It separates the frame end from the last bit by one cycle, then sends at least sixteen more strobes. Strobes come either every cycle or every other cycle, so that the hold property sees cycles without a strobe.

// File: rtl/rx_nib_pkg.sv
package rx_nib_pkg;
  localparam int NIB_W = 4;
  localparam int PH_W  = $clog2(NIB_W);
  localparam logic [NIB_W-1:0] NIB_PRE = 4'h5;
  localparam logic [NIB_W-1:0] NIB_SFD = 4'hD;

  typedef enum logic [1:0] {
    ST_HUNT,
    ST_PRE,
    ST_DATA,
    ST_FLUSH
  } rx_st_e;

  // Received bits sit in the upper n positions of sh. Move them down and fill above with ones.
  function automatic logic [NIB_W-1:0] pad_nib(input logic [NIB_W-1:0] sh, input logic [PH_W-1:0] n);
    logic [NIB_W-1:0] r;
    int idx;
    for (int k = 0; k < NIB_W; k++) begin
      idx = k + NIB_W - int'(n);
      if (k < int'(n)) r[k] = sh[idx[PH_W-1:0]];
      else             r[k] = 1'b1;
    end
    return r;
  endfunction
endpackage

// File: rtl/rx_nib_pre_det.sv
module rx_nib_pre_det #(
  parameter int PRE_BITS = 8
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic clr_i,
  input  logic vld_i,
  input  logic bit_i,
  output logic hit_o
);
  localparam int CW = $clog2(PRE_BITS + 1);

  logic [CW-1:0] cnt_q, cnt_nxt;
  logic          last_q;

  always_comb begin
    if (cnt_q == '0 || bit_i != last_q)
      cnt_nxt = (cnt_q >= CW'(PRE_BITS)) ? cnt_q : cnt_q + 1'b1;
    else
      cnt_nxt = CW'(1);
  end

  // Fire on a 0 bit so that the next bit (a 1) starts an aligned nibble
  assign hit_o = vld_i && !clr_i && !bit_i && (cnt_nxt >= CW'(PRE_BITS));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q  <= '0;
      last_q <= 1'b0;
    end else if (clr_i) begin
      cnt_q  <= '0;
    end else if (vld_i) begin
      cnt_q  <= cnt_nxt;
      last_q <= bit_i;
    end
  end
endmodule

// File: rtl/rx_nib_asm.sv
module rx_nib_asm
  import rx_nib_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             clr_i,
  input  logic             vld_i,
  input  logic             bit_i,
  output logic             done_o,
  output logic [NIB_W-1:0] nib_o,
  output logic [NIB_W-1:0] part_o,
  output logic [PH_W-1:0]  fill_o
);
  logic [NIB_W-1:0] sh_q;
  logic [PH_W-1:0]  ph_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sh_q <= '0;
      ph_q <= '0;
    end else if (clr_i) begin
      ph_q <= '0;
    end else if (vld_i) begin
      sh_q <= {bit_i, sh_q[NIB_W-1:1]};
      ph_q <= ph_q + 1'b1;
    end
  end

  assign done_o = vld_i && !clr_i && (ph_q == PH_W'(NIB_W - 1));
  assign nib_o  = {bit_i, sh_q[NIB_W-1:1]};
  assign part_o = pad_nib(sh_q, ph_q);
  assign fill_o = ph_q;
endmodule

// File: rtl/rx_nib_fmt.sv
module rx_nib_fmt
  import rx_nib_pkg::*;
#(
  parameter int PRE_BITS = 8
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       bit_i,
  input  logic       bit_vld_i,
  input  logic       eof_i,
  input  logic       pre_pass_i,
  input  logic       crs_sync_i,
  output logic [3:0] rxd_o,
  output logic       rx_dv_o,
  output logic       crs_o
);
  rx_st_e           st_q;
  logic             hit, done;
  logic [NIB_W-1:0] nib, part, held_q, fl_nib_q;
  logic [PH_W-1:0]  fill, tick_q;
  logic             nodd_q, fl_more_q;
  logic             asm_clr;

  assign asm_clr = (st_q == ST_HUNT) || (st_q == ST_FLUSH);

  rx_nib_pre_det #(.PRE_BITS(PRE_BITS)) u_det (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .clr_i  (st_q != ST_HUNT),
    .vld_i  (bit_vld_i),
    .bit_i  (bit_i),
    .hit_o  (hit)
  );

  rx_nib_asm u_asm (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .clr_i  (asm_clr),
    .vld_i  (bit_vld_i),
    .bit_i  (bit_i),
    .done_o (done),
    .nib_o  (nib),
    .part_o (part),
    .fill_o (fill)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q      <= ST_HUNT;
      rxd_o     <= '0;
      rx_dv_o   <= 1'b0;
      crs_o     <= 1'b0;
      held_q    <= '0;
      nodd_q    <= 1'b0;
      fl_more_q <= 1'b0;
      fl_nib_q  <= '0;
      tick_q    <= '0;
    end else begin
      unique case (st_q)
        ST_HUNT: begin
          if (hit) begin
            st_q   <= ST_PRE;
            held_q <= NIB_PRE;
            crs_o  <= !pre_pass_i;
          end
        end
        ST_PRE: begin
          if (eof_i || (done && nib != NIB_PRE && nib != NIB_SFD)) begin
            st_q    <= ST_HUNT;
            rx_dv_o <= 1'b0;
            crs_o   <= 1'b0;
            rxd_o   <= '0;
          end else if (done && nib == NIB_PRE) begin
            held_q <= NIB_PRE;
            if (pre_pass_i) begin
              rx_dv_o <= 1'b1;
              crs_o   <= 1'b1;
              rxd_o   <= held_q;
            end
          end else if (done) begin
            rx_dv_o <= 1'b1;
            crs_o   <= 1'b1;
            rxd_o   <= held_q;
            held_q  <= nib;
            nodd_q  <= 1'b0;
            st_q    <= ST_DATA;
          end
        end
        ST_DATA: begin
          if (eof_i) begin
            rxd_o     <= held_q;
            fl_more_q <= !nodd_q && (fill != '0);  // 1..3 bits past a byte
            fl_nib_q  <= part;
            tick_q    <= '0;
            st_q      <= ST_FLUSH;
            if (!crs_sync_i) crs_o <= 1'b0;
          end else if (done) begin
            rxd_o  <= held_q;
            held_q <= nib;
            nodd_q <= !nodd_q;
          end
        end
        ST_FLUSH: begin
          if (bit_vld_i) begin
            tick_q <= tick_q + 1'b1;
            if (tick_q == PH_W'(NIB_W - 1)) begin
              if (fl_more_q) begin
                rxd_o     <= fl_nib_q;
                fl_more_q <= 1'b0;
              end else begin
                st_q    <= ST_HUNT;
                rx_dv_o <= 1'b0;
                crs_o   <= 1'b0;
                rxd_o   <= '0;
              end
            end
          end
        end
        default: st_q <= ST_HUNT;
      endcase
    end
  end
endmodule

// File: rtl/rx_nib_fmt_chk.sv
module rx_nib_fmt_chk (
  input logic       clk_i,
  input logic       rst_ni,
  input logic       bit_vld_i,
  input logic       eof_i,
  input logic       pre_pass_i,
  input logic       crs_sync_i,
  input logic [3:0] rxd_o,
  input logic       rx_dv_o,
  input logic       crs_o
);
  // input assumption
  in_excl_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    eof_i |-> !bit_vld_i);

  // R1
  idle_zero_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !rx_dv_o |-> rxd_o == 4'h0);

  // R6
  hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!bit_vld_i && !eof_i) |=> ($stable(rxd_o) && $stable(rx_dv_o)));

  // R3
  first_nib_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(rx_dv_o) |-> rxd_o == 4'h5);

  // R3
  strip_crs_lead_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!pre_pass_i && $rose(rx_dv_o)) |-> $past(crs_o));

  // R4
  pass_align_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pre_pass_i && $rose(rx_dv_o)) |-> $rose(crs_o));

  // R9
  sync_cover_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (crs_sync_i && rx_dv_o) |-> crs_o);

  // R9
  sync_drop_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (crs_sync_i && $fell(rx_dv_o)) |-> !crs_o);
endmodule

bind rx_nib_fmt rx_nib_fmt_chk u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .bit_vld_i  (bit_vld_i),
  .eof_i      (eof_i),
  .pre_pass_i (pre_pass_i),
  .crs_sync_i (crs_sync_i),
  .rxd_o      (rxd_o),
  .rx_dv_o    (rx_dv_o),
  .crs_o      (crs_o)
);

// File: tb/rx_nib_fmt_bench.sv
`timescale 1ns/1ps
module rx_nib_fmt_bench;
  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic       bit_i = 1'b0, bit_vld_i = 1'b0, eof_i = 1'b0;
  logic       pre_pass_i = 1'b0, crs_sync_i = 1'b0;
  logic [3:0] rxd_o;
  logic       rx_dv_o, crs_o;

  int checks = 0, errors = 0;
  int gap = 0;

  rx_nib_fmt u_rx_nib_fmt (.*);

  always #10 clk_i = ~clk_i;

  // ---------------- reference model ----------------
  int ms = 0, alt = 0, lastb = 0, held = 0, nodd = 0, tk = 0;
  int cur[$];
  int fq[$];
  int e_rxd = 0, e_dv = 0, e_crs = 0;
  bit s_vld = 0, s_eof = 0, started = 0;

  function automatic int pack4(input int q[$]);
    int v = 0;
    for (int k = 0; k < 4; k++) v += ((k < q.size()) ? q[k] : 1) << k;
    return v;
  endfunction

  always @(posedge clk_i) begin
    s_vld = bit_vld_i;
    s_eof = eof_i;
    started = 1;
    if (!rst_ni) begin
      ms = 0; alt = 0; lastb = 0; held = 0; nodd = 0; tk = 0;
      cur.delete(); fq.delete();
      e_rxd = 0; e_dv = 0; e_crs = 0;
    end else begin
      case (ms)
        0: if (bit_vld_i) begin
          if (alt == 0 || int'(bit_i) != lastb) alt = (alt >= 8) ? 8 : alt + 1;
          else alt = 1;
          lastb = int'(bit_i);
          if (alt >= 8 && bit_i == 1'b0) begin
            ms = 1; cur.delete(); held = 5;
            if (!pre_pass_i) e_crs = 1;
          end
        end
        1: if (eof_i) begin
          ms = 0; alt = 0; e_dv = 0; e_crs = 0; e_rxd = 0;
        end else if (bit_vld_i) begin
          cur.push_back(int'(bit_i));
          if (cur.size() == 4) begin
            int n;
            n = pack4(cur); cur.delete();
            if (n == 5) begin
              if (pre_pass_i) begin e_dv = 1; e_crs = 1; e_rxd = held; end
              held = 5;
            end else if (n == 13) begin
              e_dv = 1; e_crs = 1; e_rxd = held; held = 13; nodd = 0; ms = 2;
            end else begin
              ms = 0; alt = 0; e_dv = 0; e_crs = 0; e_rxd = 0;
            end
          end
        end
        2: if (eof_i) begin
          e_rxd = held;
          if (nodd == 0 && cur.size() > 0) fq.push_back(pack4(cur));
          cur.delete();
          if (!crs_sync_i) e_crs = 0;
          tk = 0; ms = 3;
        end else if (bit_vld_i) begin
          cur.push_back(int'(bit_i));
          if (cur.size() == 4) begin
            e_rxd = held; held = pack4(cur); cur.delete(); nodd = 1 - nodd;
          end
        end
        default: if (bit_vld_i) begin
          tk++;
          if (tk == 4) begin
            tk = 0;
            if (fq.size() > 0) e_rxd = fq.pop_front();
            else begin e_dv = 0; e_crs = 0; e_rxd = 0; ms = 0; alt = 0; end
          end
        end
      endcase
    end
  end

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h t=%0t", tag, act, exp, $time);
    end
  endtask

  // ---------------- per-cycle compare and nibble recorder ----------------
  int rec[$];
  int scnt = 0;
  bit dv_q = 0;

  always @(negedge clk_i) begin
    if (started && rst_ni) begin
      check(int'(rxd_o) == e_rxd, "R6 rxd", int'(rxd_o), e_rxd);
      check(int'(rx_dv_o) == e_dv, "R3 dv", int'(rx_dv_o), e_dv);
      check(int'(crs_o) == e_crs, "R9 crs", int'(crs_o), e_crs);
      if (s_vld) scnt++;
      if (rx_dv_o && (!dv_q || s_eof || scnt == 4)) begin
        rec.push_back(int'(rxd_o));
        scnt = 0;
      end
      if (!rx_dv_o) scnt = 0;
      dv_q = rx_dv_o;
    end
  end

  // ---------------- stimulus ----------------
  task automatic drive(input bit v, input bit b, input bit e);
    @(negedge clk_i);
    bit_vld_i = v; bit_i = b; eof_i = e;
    if (v) repeat (gap) begin
      @(negedge clk_i);
      bit_vld_i = 1'b0; eof_i = 1'b0;
    end
  endtask

  task automatic send_frame(input bit pass, input bit sync, input int pre_bits, input int nbytes,
                            input int extra, input bit bad, input bit early, input bit noise,
                            input string tag);
    int bits[$];
    int body[$];
    int exp[$];
    @(negedge clk_i);
    pre_pass_i = pass; crs_sync_i = sync;
    rec.delete();
    if (noise) begin bits.push_back(0); bits.push_back(0); bits.push_back(1);
                     bits.push_back(1); bits.push_back(0); bits.push_back(0); end
    for (int i = 0; i < pre_bits; i++) bits.push_back((i % 2 == 0) ? 1 : 0);
    if (bad) begin
      repeat (4) bits.push_back(1);
    end else if (!early) begin
      bits.push_back(1); bits.push_back(0); bits.push_back(1); bits.push_back(1);
      for (int i = 0; i < nbytes * 8 + extra; i++) body.push_back(int'($urandom_range(0, 1)));
      foreach (body[i]) bits.push_back(body[i]);
    end
    foreach (bits[i]) drive(1'b1, bits[i][0], 1'b0);
    drive(1'b0, 1'b0, 1'b1);
    for (int i = 0; i < 8; i++) drive(1'b1, (i % 2 == 0), 1'b0);  // ignored during drain
    repeat (8) drive(1'b1, 1'b1, 1'b0);
    drive(1'b0, 1'b0, 1'b0);
    repeat (3) @(negedge clk_i);

    if (!bad && !early) begin
      if (pass) repeat ((pre_bits - 8) / 4 + 1) exp.push_back(5);
      else exp.push_back(5);
      exp.push_back(13);
      for (int i = 0; i < nbytes * 2 + (extra >= 4 ? 1 : 0); i++) begin
        int v = 0;
        for (int k = 0; k < 4; k++) v += body[i * 4 + k] << k;
        exp.push_back(v);
      end
      if (extra >= 1 && extra <= 3) begin
        int v = 0;
        for (int k = 0; k < 4; k++) v += ((k < extra) ? body[nbytes * 8 + k] : 1) << k;
        exp.push_back(v);
      end
    end
    check(rec.size() == exp.size(), {tag, " nibble count"}, rec.size(), exp.size());
    foreach (exp[i]) if (i < rec.size())
      check(rec[i] == exp[i], {tag, " nibble value"}, rec[i], exp[i]);
    check(!rx_dv_o && !crs_o, "R10 idle after frame", {rx_dv_o, crs_o}, 0);
  endtask

  initial begin
    #(20 * 200000);
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk_i);
    check(rxd_o == 4'h0 && !rx_dv_o && !crs_o, "R1 reset", {rxd_o, rx_dv_o, crs_o}, 0);
    rst_ni = 1'b1;
    @(negedge clk_i);
    check(rxd_o == 4'h0 && !rx_dv_o && !crs_o, "R1 after reset", {rxd_o, rx_dv_o, crs_o}, 0);

    gap = 0;
    send_frame(0, 0, 16, 3, 0, 0, 0, 0, "R3 strip");
    send_frame(0, 1, 12, 2, 2, 0, 0, 0, "R7 pad2");
    gap = 1;
    send_frame(1, 0, 12, 2, 4, 0, 0, 0, "R4 pass");
    send_frame(1, 1, 8, 1, 6, 0, 0, 0, "R8 drop");
    gap = 0;
    send_frame(0, 0, 8, 2, 7, 0, 0, 0, "R8 strip7");
    send_frame(1, 0, 20, 1, 1, 0, 0, 0, "R7 pad1");
    send_frame(0, 1, 16, 1, 3, 0, 0, 0, "R10 drain");
    send_frame(0, 0, 16, 1, 5, 0, 0, 1, "R2 noise");
    send_frame(0, 0, 12, 0, 0, 1, 0, 0, "R5 bad nibble");
    send_frame(0, 0, 16, 0, 0, 0, 1, 0, "R5 early eof");
    gap = 1;
    send_frame(0, 1, 8, 4, 0, 0, 0, 0, "R6 slow strobe");

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule